// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a parallel NOR flash controller. It watches the stream of host write cycles (a word address, a data word and a one-cycle write enable) and recognises the keyed unlock-and-command sequences. When a sequence completes and the current state allows it, the block issues a one-cycle operation request. The request carries an operation code and the operands latched from the bus. The cases are program, chip erase, sector erase, suspend, resume, reset, autoselect entry, CFI query entry, and entry to and exit from a shortened "bypass" command mode.

The decoder keeps a read-mode state (array, autoselect, CFI query) and a job state: idle, program running, chip erase running, sector erase running, or erase suspended. The job state starts when a program or erase request is issued and ends when the caller pulses `eng_done`, which stands in for the embedded algorithm. The job state decides which commands are honoured. Only the low twelve address bits and the low data byte take part in matching, except where an operand is latched.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A command prefix is data 0xAA at low address 0x555 followed by data 0x55 at low address 0x2AA. Only `wr_addr[11:0]` and `wr_data[7:0]` are compared, and all higher bits are ignored.
- R2: Prefix then 0xA0 at 0x555 then any write gives a program request (op 1). It carries the full address and full data of that last write, which is taken as data even if it is 0xF0. `job_busy` rises in the same cycle.
- R3: Prefix, 0x80/0x555, prefix, then 0x10/0x555 gives chip erase (op 2) with address and data zero. `job_busy` rises.
- R4: The same five writes followed by 0x30 at any address give sector erase (op 3). Its address is the write address with bits 11:0 cleared.
- R5: While not busy and not in a program data step, 0xF0 at any address gives reset (op 6). Reset aborts any partial sequence and sets `rd_mode` to array (0). It leaves the suspended job state and bypass mode unchanged.
- R6: 0x98 at low address 0x055 gives CFI entry (op 8) and `rd_mode` 2. It is honoured only from array mode with no sequence in progress and bypass off, or from autoselect mode.
- R7: Prefix then 0x90 at 0x555 gives autoselect entry (op 7), with address bits 21:19 kept and all others zero, and `rd_mode` 1. In autoselect or CFI mode, every write other than 0xF0 is ignored, and so is 0x98 in CFI mode.
- R8: 0xB0 at any address while a sector erase runs gives suspend (op 4) with the bank address. `job_busy` falls and `job_suspended` rises. At any other time 0xB0 is ignored.
- R9: 0x30 with no sequence in progress, while suspended and in array mode, gives resume (op 5) with the bank address, and the sector erase is busy again. When not suspended, 0x30 is ignored.
- R10: Prefix then 0x20/0x555 gives bypass entry (op 9) and `bypass_on` is set. In bypass mode, 0xA0 at any address then any write gives a program request (op 1). 0x90 then 0x00 at any addresses gives bypass exit (op 10) and clears `bypass_on`.
- R11: From a program or erase request until `eng_done` is pulsed, every write except the R8 suspend is ignored, including 0xF0.
- R12: A write that does not match the expected step returns the decoder to idle with no request. `req_valid` is high for exactly the cycle after the completing write. When `req_valid` is low, `req_op`, `req_addr` and `req_data` are zero.
- R13: While suspended, program and erase sequences complete without a request, and the decoder returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One host write cycle this clock |
| wr_addr | input | 22 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| eng_done | input | 1 | Embedded algorithm finished (one-cycle pulse) |
| req_valid | output | 1 | Operation request strobe |
| req_op | output | 4 | Operation code |
| req_addr | output | 22 | Latched operand address |
| req_data | output | 16 | Latched operand data |
| rd_mode | output | 2 | 0 array, 1 autoselect, 2 CFI |
| bypass_on | output | 1 | Bypass command mode active |
| job_busy | output | 1 | Program or erase running |
| job_suspended | output | 1 | Sector erase suspended |

## Verification
The hardest situation to reach is a suspended sector erase that is then driven through program, erase, bypass and reset traffic. Reaching it needs a complete six-write erase, then a B0 before any done pulse, then further full sequences. The random stimulus uses whole-command fragments rather than single writes, with only occasional corrupted data bytes and random upper address bits. The done pulse is kept rare, so the suspend and resume windows open often. Directed sequences cover this path explicitly as well: a program and an erase attempted while suspended, and suspend and resume attempted in the wrong job states.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW       = 22,
  parameter int DW       = 16,
  parameter int BANK_LSB = 19,
  parameter int SECT_LSB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          eng_done,
  output logic          req_valid,
  output logic [3:0]    req_op,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic [1:0]    rd_mode,
  output logic          bypass_on,
  output logic          job_busy,
  output logic          job_suspended
);
  localparam logic [AW-1:0] BANK_MASK = {AW{1'b1}} << BANK_LSB;
  localparam logic [AW-1:0] SECT_MASK = {AW{1'b1}} << SECT_LSB;

  localparam logic [3:0] OP_NONE = 4'd0, OP_PROG = 4'd1, OP_CHIP = 4'd2, OP_SECT = 4'd3,
                         OP_SUSP = 4'd4, OP_RESUME = 4'd5, OP_RESET = 4'd6, OP_AUTO = 4'd7,
                         OP_CFI = 4'd8, OP_BYP_IN = 4'd9, OP_BYP_OUT = 4'd10;
  localparam logic [1:0] M_ARRAY = 2'd0, M_AUTO = 2'd1, M_CFI = 2'd2;
  localparam logic [2:0] J_IDLE = 3'd0, J_PROG = 3'd1, J_CHIP = 3'd2, J_SECT = 3'd3, J_SUSP = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PRG, S_E3, S_E4, S_E5, S_BPRG, S_BEXIT
  } step_t;

  step_t step, n_step;
  logic [2:0] job, n_job;
  logic [1:0] n_mode;
  logic n_byp, hit;
  logic [3:0] op;
  logic [AW-1:0] oa;
  logic [DW-1:0] od;

  wire [11:0] lo   = wr_addr[11:0];
  wire [7:0]  d    = wr_data[7:0];
  wire k555 = lo == 12'h555;
  wire k2aa = lo == 12'h2AA;
  wire k055 = lo == 12'h055;
  wire busy = job == J_PROG || job == J_CHIP || job == J_SECT;
  wire susp = job == J_SUSP;
  wire data_step = step == S_PRG || step == S_BPRG;

  assign job_busy = busy;
  assign job_suspended = susp;

  always_comb begin
    n_step = S_IDLE;
    n_mode = rd_mode;
    n_byp  = bypass_on;
    n_job  = (busy && eng_done) ? J_IDLE : job;
    hit = 1'b0; op = OP_NONE; oa = '0; od = '0;
    if (!wr_en) begin
      n_step = step;
    end else if (busy) begin
      // R11, R8
      n_step = step;
      if (d == 8'hB0 && job == J_SECT && !eng_done) begin
        hit = 1'b1; op = OP_SUSP; oa = wr_addr & BANK_MASK; n_job = J_SUSP;
      end
    end else if (data_step) begin
      // R2, R10, R13
      if (!susp) begin
        hit = 1'b1; op = OP_PROG; oa = wr_addr; od = wr_data; n_job = J_PROG;
      end
    end else if (d == 8'hF0) begin
      // R5
      hit = 1'b1; op = OP_RESET; n_mode = M_ARRAY;
    end else if (rd_mode != M_ARRAY) begin
      // R7
      if (rd_mode == M_AUTO && d == 8'h98 && k055) begin
        hit = 1'b1; op = OP_CFI; n_mode = M_CFI;
      end
    end else if (step == S_IDLE && d == 8'h30 && susp) begin
      // R9
      hit = 1'b1; op = OP_RESUME; oa = wr_addr & BANK_MASK; n_job = J_SECT;
    end else if (bypass_on) begin
      // R10
      case (step)
        S_IDLE:  if (d == 8'hA0) n_step = S_BPRG; else if (d == 8'h90) n_step = S_BEXIT;
        S_BEXIT: if (d == 8'h00) begin hit = 1'b1; op = OP_BYP_OUT; n_byp = 1'b0; end
        default: ;
      endcase
    end else begin
      // R1, R12
      case (step)
        S_IDLE:
          if (d == 8'hAA && k555) n_step = S_U1;
          else if (d == 8'h98 && k055) begin hit = 1'b1; op = OP_CFI; n_mode = M_CFI; end
        S_U1: if (d == 8'h55 && k2aa) n_step = S_U2;
        S_U2:
          if (k555) begin
            case (d)
              8'hA0: n_step = S_PRG;
              8'h80: n_step = S_E3;
              8'h90: begin hit = 1'b1; op = OP_AUTO; oa = wr_addr & BANK_MASK; n_mode = M_AUTO; end
              8'h20: begin hit = 1'b1; op = OP_BYP_IN; n_byp = 1'b1; end
              default: ;
            endcase
          end
        S_E3: if (d == 8'hAA && k555) n_step = S_E4;
        S_E4: if (d == 8'h55 && k2aa) n_step = S_E5;
        S_E5:
          // R3, R4, R13
          if (!susp && d == 8'h10 && k555) begin
            hit = 1'b1; op = OP_CHIP; n_job = J_CHIP;
          end else if (!susp && d == 8'h30) begin
            hit = 1'b1; op = OP_SECT; oa = wr_addr & SECT_MASK; n_job = J_SECT;
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= S_IDLE; job <= J_IDLE; rd_mode <= M_ARRAY; bypass_on <= 1'b0;
      req_valid <= 1'b0; req_op <= OP_NONE; req_addr <= '0; req_data <= '0;
    end else begin
      step <= n_step; job <= n_job; rd_mode <= n_mode; bypass_on <= n_byp;
      req_valid <= hit; req_op <= op; req_addr <= oa; req_data <= od;
    end
  end

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (job_busy && wr_en && wr_data[7:0] != 8'hB0) |=> !req_valid);
  // R8
  susp_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(job_suspended) |-> (req_valid && req_op == OP_SUSP));
  // R10
  byp_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_on) |-> (req_valid && req_op == OP_BYP_IN));
  // R6
  cfi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_CFI) |-> rd_mode == M_CFI);
  // R5
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_RESET) |-> rd_mode == M_ARRAY);
  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (req_op == OP_NONE && req_addr == '0 && req_data == '0));
endmodule

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, eng_done = 1'b0;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic req_valid, bypass_on, job_busy, job_suspended;
  logic [3:0] req_op;
  logic [21:0] req_addr;
  logic [15:0] req_data;
  logic [1:0] rd_mode;

  always #10 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_done(eng_done), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .rd_mode(rd_mode), .bypass_on(bypass_on),
    .job_busy(job_busy), .job_suspended(job_suspended));

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench reference state
  int m_step = 0, m_mode = 0, m_job = 0;
  bit m_byp = 0;
  bit e_valid;
  logic [3:0] e_op;
  logic [21:0] e_addr;
  logic [15:0] e_data;
  string tag;

  localparam int IDLE = 0, U1 = 1, U2 = 2, PRG = 3, E3 = 4, E4 = 5, E5 = 6, BPRG = 7, BEXIT = 8;
  localparam logic [21:0] BANK = 22'h380000, SECT = 22'h3FF000;

  task automatic emit(input logic [3:0] op, input logic [21:0] a, input logic [15:0] dd);
    e_valid = 1; e_op = op; e_addr = a; e_data = dd;
  endtask

  task automatic model(input logic [21:0] a, input logic [15:0] dd);
    logic [7:0] d;
    logic [11:0] lo;
    int nx;
    d = dd[7:0]; lo = a[11:0]; nx = IDLE;
    e_valid = 0; e_op = 0; e_addr = 0; e_data = 0; tag = "R12";
    if (m_job >= 1 && m_job <= 3) begin
      tag = "R11"; nx = m_step;
      if (d == 8'hB0 && m_job == 3) begin emit(4, a & BANK, 0); m_job = 4; tag = "R8"; end
    end else if (m_step == PRG || m_step == BPRG) begin
      tag = (m_step == PRG) ? "R2" : "R10";
      if (m_job == 4) tag = "R13";
      else begin emit(1, a, dd); m_job = 1; end
    end else if (d == 8'hF0) begin
      emit(6, 0, 0); m_mode = 0; tag = "R5";
    end else if (m_mode != 0) begin
      tag = "R7";
      if (m_mode == 1 && d == 8'h98 && lo == 12'h055) begin emit(8, 0, 0); m_mode = 2; tag = "R6"; end
    end else if (m_step == IDLE && d == 8'h30 && m_job == 4) begin
      emit(5, a & BANK, 0); m_job = 3; tag = "R9";
    end else if (m_byp) begin
      tag = "R10";
      if (m_step == IDLE && d == 8'hA0) nx = BPRG;
      else if (m_step == IDLE && d == 8'h90) nx = BEXIT;
      else if (m_step == BEXIT && d == 8'h00) begin emit(10, 0, 0); m_byp = 0; end
    end else begin
      if (m_step == IDLE) begin
        if (d == 8'hAA && lo == 12'h555) begin nx = U1; tag = "R1"; end
        else if (d == 8'h98 && lo == 12'h055) begin emit(8, 0, 0); m_mode = 2; tag = "R6"; end
        else if (d == 8'h30 || d == 8'hB0) tag = (d == 8'h30) ? "R9" : "R8";
      end else if (m_step == U1) begin
        if (d == 8'h55 && lo == 12'h2AA) begin nx = U2; tag = "R1"; end
      end else if (m_step == U2 && lo == 12'h555) begin
        if (d == 8'hA0) begin nx = PRG; tag = "R2"; end
        else if (d == 8'h80) begin nx = E3; tag = "R3"; end
        else if (d == 8'h90) begin emit(7, a & BANK, 0); m_mode = 1; tag = "R7"; end
        else if (d == 8'h20) begin emit(9, 0, 0); m_byp = 1; tag = "R10"; end
      end else if (m_step == E3) begin
        if (d == 8'hAA && lo == 12'h555) begin nx = E4; tag = "R3"; end
      end else if (m_step == E4) begin
        if (d == 8'h55 && lo == 12'h2AA) begin nx = E5; tag = "R4"; end
      end else if (m_step == E5) begin
        if (m_job == 4) tag = "R13";
        else if (d == 8'h10 && lo == 12'h555) begin emit(2, 0, 0); m_job = 2; tag = "R3"; end
        else if (d == 8'h30) begin emit(3, a & SECT, 0); m_job = 3; tag = "R4"; end
      end
    end
    m_step = nx;
  endtask

  task automatic compare();
    checks++;
    if (req_valid !== e_valid || req_op !== e_op || req_addr !== e_addr || req_data !== e_data ||
        rd_mode !== 2'(m_mode) || bypass_on !== m_byp ||
        job_busy !== (m_job >= 1 && m_job <= 3) || job_suspended !== (m_job == 4)) begin
      fails++;
      $display("FAIL %s: got v=%0d op=%0d a=%h d=%h mode=%0d byp=%0d busy=%0d susp=%0d exp v=%0d op=%0d a=%h d=%h mode=%0d byp=%0d job=%0d",
        tag, req_valid, req_op, req_addr, req_data, rd_mode, bypass_on, job_busy, job_suspended,
        e_valid, e_op, e_addr, e_data, m_mode, m_byp, m_job);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [15:0] dd);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = dd; model(a, dd);
    @(negedge clk); wr_en = 0; compare();
  endtask

  task automatic done();
    @(negedge clk); eng_done = 1;
    if (m_job >= 1 && m_job <= 3) m_job = 0;
    e_valid = 0; e_op = 0; e_addr = 0; e_data = 0; tag = "R11";
    @(negedge clk); eng_done = 0; compare();
  endtask

  function automatic logic [21:0] ad(input logic [11:0] lo);
    return {10'($urandom), lo};
  endfunction
  function automatic logic [15:0] dz(input logic [7:0] v);
    if ($urandom % 30 == 0) return 16'($urandom);
    return {8'($urandom), v};
  endfunction

  task automatic prefix(); wr(ad(12'h555), dz(8'hAA)); wr(ad(12'h2AA), dz(8'h55)); endtask
  task automatic erase6(input bit sect);
    prefix(); wr(ad(12'h555), dz(8'h80)); prefix();
    if (sect) wr(ad(12'($urandom)), dz(8'h30)); else wr(ad(12'h555), dz(8'h10));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    e_valid = 0; e_op = 0; e_addr = 0; e_data = 0; tag = "R12";
    compare();                         // reset state
    rst_n = 1;
    @(negedge clk);
    // R2 program with stray upper bits (R1)
    wr(22'h3AB555, 16'hC3AA); wr(22'h1552AA, 16'h0055); wr(22'h200555, 16'h77A0);
    wr(22'h2ABCDE, 16'hF0F0);
    // R11 busy ignores reset and suspend on program
    wr(22'h0, 16'h00F0); wr(22'h0, 16'h00B0); done();
    // R3 chip erase
    wr(22'h555, 16'hAA); wr(22'h2AA, 16'h55); wr(22'h555, 16'h80);
    wr(22'h555, 16'hAA); wr(22'h2AA, 16'h55); wr(22'h555, 16'h10);
    wr(22'h080000, 16'hB0); done();            // R8 chip erase not suspendable
    // R9 resume while idle ignored
    wr(22'h080000, 16'h30);
    // R4 sector erase, R8 suspend, R13 program while suspended
    wr(22'h555, 16'hAA); wr(22'h2AA, 16'h55); wr(22'h555, 16'h80);
    wr(22'h555, 16'hAA); wr(22'h2AA, 16'h55); wr(22'h2B4ABC, 16'h30);
    wr(22'h2B4000, 16'hB0);
    wr(22'h555, 16'hAA); wr(22'h2AA, 16'h55); wr(22'h555, 16'hA0); wr(22'h001234, 16'h5678);
    wr(22'h0, 16'hF0);                         // R5 keeps suspension
    wr(22'h280000, 16'h30); done();            // R9
    // R12 mismatch midway then F0 mid-sequence
    wr(22'h555, 16'hAA); wr(22'h2AB, 16'h55); wr(22'h555, 16'hA0);
    wr(22'h555, 16'hAA); wr(22'h123456, 16'hF0); wr(22'h2AA, 16'h55);
    // R7 autoselect then R6 CFI then reset
    wr(22'h555, 16'hAA); wr(22'h2AA, 16'h55); wr(22'h3C0555, 16'h90);
    wr(22'h555, 16'hAA); wr(22'h055, 16'h98); wr(22'h055, 16'h98); wr(22'h0, 16'hF0);
    wr(22'h055, 16'h98); wr(22'h0, 16'hF0);
    // R10 bypass
    wr(22'h555, 16'hAA); wr(22'h2AA, 16'h55); wr(22'h555, 16'h20);
    wr(22'h000777, 16'hA0); wr(22'h3FFFFF, 16'hBEEF); done();
    wr(22'h000000, 16'h90); wr(22'h000001, 16'h00);
    // constrained random
    for (int i = 0; i < 700; i++) begin
      case ($urandom % 14)
        0: begin prefix(); wr(ad(12'h555), dz(8'hA0)); wr(22'($urandom), 16'($urandom)); end
        1: erase6(0);
        2, 3: erase6(1);
        4: begin prefix(); wr(ad(12'h555), dz(8'h90)); end
        5: wr(ad(12'h055), dz(8'h98));
        6: wr(ad(12'($urandom)), dz(8'hF0));
        7: wr(ad(12'($urandom)), dz(8'hB0));
        8: wr(ad(12'($urandom)), dz(8'h30));
        9: begin prefix(); wr(ad(12'h555), dz(8'h20)); end
        10: begin wr(ad(12'($urandom)), dz(8'hA0)); wr(22'($urandom), 16'($urandom)); end
        11: begin wr(ad(12'($urandom)), dz(8'h90)); wr(ad(12'($urandom)), dz(8'h00)); end
        12: wr(22'($urandom), 16'($urandom));
        default: done();
      endcase
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule